// File: doc/BRIEF.md
# Cache Tag-Access Elimination Buffer

This block sits beside a set-associative cache and remembers, for a handful of recently used lines, the pair of tag and set index together with the way in which that line was found. Each request address is compared against every remembered pair in the same cycle. When one matches, the block tells the cache to skip the tag array read and the tag compare, and to enable only the remembered data way. When nothing matches, every tag way and every data way is enabled, as in a plain lookup. The cache returns its hit flag and hit way one cycle later, and a cache hit is then written into the buffer. No data is stored here, so each entry costs only a key and a way number, and the block adds no cycle and no stall.

The entries are kept in most-recently-used order. A buffer hit or a new fill moves that pair to the front. A fill into a full buffer drops the least recently used pair. When the cache replaces or flushes a line, it signals an invalidation with that line's address, and any matching entry is cleared so that a stale way is never trusted.

A two-state controller tracks whether a tag lookup result is due. `ST_IDLE` means no lookup is outstanding. `ST_AWAIT` means the previous cycle had a buffer miss, so the cache result is taken this cycle. The transition *miss* (a valid request that the buffer did not catch) goes from either state to `ST_AWAIT`. The transition *no-miss* (no request, or a buffer hit) goes from either state to `ST_IDLE`.

Top module: `tagskip_buf`

## Requirements
- R1: After reset every entry is invalid, so the first request to any address has `skip` low.
- R2: When `req_valid` is high and `skip` is low, `tag_en` and `data_en` are all ones (both are 2'b11 by default). When `req_valid` is low, both are all zeros.
- R3: When a valid request matches a valid entry, `skip` goes high in the same cycle as the request and `tag_en` is all zeros.
- R4: On a buffer hit, `data_en` is one-hot with bit `w` set, where `w` is the way stored with the matching entry. That way is the one that holds the line in the cache.
- R5: `rsp_hit` and `rsp_way` are used only in the cycle right after a buffer miss. If `rsp_hit` is high there, the missed key is stored with way `rsp_way`. In any other cycle they have no effect on later `skip` results.
- R6: A buffer hit or a fill makes that key the most recently used. A fill into a buffer holding `ENTRIES` (default 4) valid keys evicts the least recently used key.
- R7: An invalidation clears the entry whose key equals `inv_addr`'s key. A request in the same cycle with that key has `skip` low. A pending fill of that key in the same cycle is dropped.
- R8: The key is the address without its line offset. With the defaults, bits 4:0 are ignored, bits 13:5 are the set index and bits 31:14 are the tag. Addresses that differ only in bits 4:0 share an entry.
- R9: Back-to-back misses are each filled from the result returned in the cycle after their own request. The controller is in `ST_AWAIT` exactly in the cycles that follow a miss.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_addr | input | ADDR_W | Byte address of the access |
| rsp_hit | input | 1 | Cache tag lookup hit, for the previous cycle's missed access |
| rsp_way | input | clog2(WAYS) | Way that hit in that lookup |
| inv_valid | input | 1 | A cache line is being replaced or flushed |
| inv_addr | input | ADDR_W | Address of the line being removed |
| tag_en | output | WAYS | Per-way tag array read enable |
| data_en | output | WAYS | Per-way data array enable |
| skip | output | 1 | The tag access was skipped for this request |

## Verification
A wrong entry or a wrong order shows only when a later request uses the key it touches. A corrupted way appears as a one-hot `data_en` that disagrees with the bench's cache model in that request's own cycle. An entry that was lost or kept by mistake appears as a `skip` that differs from the bench's most-recently-used list. This can stay hidden for as many cycles as pass before the key comes back, so the random phase reuses a small pool of sixteen keys against four entries. A controller stuck in the wrong state shows up one cycle later, as a fill that is missing or that should not have happened.

// File: rtl/tagskip_pkg.sv
`timescale 1ns/1ps
package tagskip_pkg;
    // Controller state: is a tag lookup result due this cycle?
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_AWAIT = 1'b1
    } tsk_state_e;
endpackage

// File: rtl/tagskip_match.sv
`timescale 1ns/1ps
// Parallel key comparator across all buffer entries.
// Entry layout: {valid, key[KEY_W], way[WAY_W]}
module tagskip_match #(
    parameter int N     = 4,
    parameter int KEY_W = 27,
    parameter int WAY_W = 1,
    parameter int ENT_W = 1 + KEY_W + WAY_W
) (
    input  logic [N-1:0][ENT_W-1:0] tbl,
    input  logic [KEY_W-1:0]        key,
    output logic [N-1:0]            hit
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit[i] = tbl[i][ENT_W-1] && (tbl[i][ENT_W-2:WAY_W] == key);
    end
endmodule

// File: rtl/tagskip_wayen.sv
`timescale 1ns/1ps
// Per-way enable decode for tag and data arrays.
module tagskip_wayen #(
    parameter int WAYS  = 2,
    parameter int WAY_W = 1
) (
    input  logic             req,
    input  logic             skip,
    input  logic [WAY_W-1:0] way,
    output logic [WAYS-1:0]  tag_en,
    output logic [WAYS-1:0]  data_en
);
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign tag_en[w]  = req && !skip;
        assign data_en[w] = req && (!skip || (way == WAY_W'(w)));
    end
endmodule

// File: rtl/tagskip_fsm.sv
`timescale 1ns/1ps
// Tracks whether the cache lookup result belongs to a buffer miss.
module tagskip_fsm
    import tagskip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       miss,
    output tsk_state_e state,
    output logic       take_rsp
);
    tsk_state_e state_d;

    always_comb begin
        state_d = state;
        unique case (state)
            ST_IDLE:  state_d = miss ? ST_AWAIT : ST_IDLE;
            ST_AWAIT: state_d = miss ? ST_AWAIT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_d;
    end

    always_comb begin
        unique case (state)
            ST_IDLE:  take_rsp = 1'b0;
            ST_AWAIT: take_rsp = 1'b1;
            default:  take_rsp = 1'b0;
        endcase
    end
endmodule

// File: rtl/tagskip_buf.sv
`timescale 1ns/1ps
// Fully associative MRU buffer of {tag, set index, way} that lets a
// set-associative cache skip its tag read and unused data ways.
module tagskip_buf
    import tagskip_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int CACHE_BYTES = 32768,
    parameter int WAYS        = 2,
    parameter int LINE_BYTES  = 32,
    parameter int ENTRIES     = 4
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    req_valid,
    input  logic [ADDR_W-1:0]                       req_addr,
    input  logic                                    rsp_hit,
    input  logic [((WAYS > 1) ? $clog2(WAYS) : 1)-1:0] rsp_way,
    input  logic                                    inv_valid,
    input  logic [ADDR_W-1:0]                       inv_addr,
    output logic [WAYS-1:0]                         tag_en,
    output logic [WAYS-1:0]                         data_en,
    output logic                                    skip
);
    localparam int OFF_W = $clog2(LINE_BYTES);
    localparam int SETS  = CACHE_BYTES / (LINE_BYTES * WAYS);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
    localparam int KEY_W = TAG_W + IDX_W;
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
    localparam int ENT_W = 1 + KEY_W + WAY_W;

    typedef logic [ENTRIES-1:0][ENT_W-1:0] tbl_t;

    tbl_t               tbl_q, tbl_inv, tbl_fill, tbl_d;
    logic [KEY_W-1:0]   req_key, inv_key, pend_key;
    logic [ENTRIES-1:0] req_hits, inv_hits;
    logic [WAY_W-1:0]   hit_way;
    logic               inv_on_req, inv_on_pend, miss, take_rsp, fill_go;
    tsk_state_e         state;
    logic               unused_offsets;

    // Tag and set index are adjacent above the offset, so the key is one slice.
    assign req_key        = req_addr[ADDR_W-1:OFF_W];
    assign inv_key        = inv_addr[ADDR_W-1:OFF_W];
    assign unused_offsets = ^{req_addr[OFF_W-1:0], inv_addr[OFF_W-1:0]};

    tagskip_match #(.N(ENTRIES), .KEY_W(KEY_W), .WAY_W(WAY_W), .ENT_W(ENT_W)) u_req_match (
        .tbl(tbl_q), .key(req_key), .hit(req_hits)
    );
    tagskip_match #(.N(ENTRIES), .KEY_W(KEY_W), .WAY_W(WAY_W), .ENT_W(ENT_W)) u_inv_match (
        .tbl(tbl_q), .key(inv_key), .hit(inv_hits)
    );

    always_comb begin
        hit_way = '0;
        for (int i = 0; i < ENTRIES; i++)
            if (req_hits[i]) hit_way = hit_way | tbl_q[i][WAY_W-1:0];
    end

    assign inv_on_req  = inv_valid && (inv_key == req_key);
    assign inv_on_pend = inv_valid && (inv_key == pend_key);
    assign skip        = req_valid && (|req_hits) && !inv_on_req;
    assign miss        = req_valid && !skip;
    assign fill_go     = take_rsp && rsp_hit && !inv_on_pend;

    tagskip_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .miss(miss), .state(state), .take_rsp(take_rsp)
    );

    tagskip_wayen #(.WAYS(WAYS), .WAY_W(WAY_W)) u_wayen (
        .req(req_valid), .skip(skip), .way(hit_way), .tag_en(tag_en), .data_en(data_en)
    );

    // Move key k to the front. The slot it leaves is, in order of preference:
    // its own old slot, the first invalid slot, or the LRU slot.
    function automatic tbl_t touch(input tbl_t t, input logic [KEY_W-1:0] k,
                                   input logic [WAY_W-1:0] w);
        tbl_t r;
        int   pos;
        logic got;
        got = 1'b0;
        pos = ENTRIES - 1;
        for (int i = 0; i < ENTRIES; i++)
            if (!got && t[i][ENT_W-1] && (t[i][ENT_W-2:WAY_W] == k)) begin
                got = 1'b1;
                pos = i;
            end
        for (int i = 0; i < ENTRIES; i++)
            if (!got && !t[i][ENT_W-1]) begin
                got = 1'b1;
                pos = i;
            end
        r = t;
        for (int i = ENTRIES - 1; i > 0; i--)
            if (i <= pos) r[i] = t[i-1];
        r[0] = {1'b1, k, w};
        return r;
    endfunction

    // Update order: invalidate, then fill the pending miss, then promote the hit.
    always_comb begin
        tbl_inv = tbl_q;
        for (int i = 0; i < ENTRIES; i++)
            if (inv_valid && inv_hits[i]) tbl_inv[i][ENT_W-1] = 1'b0;
        tbl_fill = fill_go ? touch(tbl_inv, pend_key, rsp_way) : tbl_inv;
        tbl_d    = skip ? touch(tbl_fill, req_key, hit_way) : tbl_fill;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q    <= '0;
            pend_key <= '0;
        end else begin
            tbl_q <= tbl_d;
            if (miss) pend_key <= req_key;
        end
    end
endmodule

// File: rtl/tagskip_chk.sv
`timescale 1ns/1ps
module tagskip_chk
    import tagskip_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 5,
    parameter int WAYS   = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              inv_valid,
    input logic [ADDR_W-1:0] inv_addr,
    input logic [WAYS-1:0]   tag_en,
    input logic [WAYS-1:0]   data_en,
    input logic              skip,
    input tsk_state_e        state
);
    logic same_key;
    assign same_key = (req_addr[ADDR_W-1:OFF_W] == inv_addr[ADDR_W-1:OFF_W]);

    AST_MISS_ALL_WAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !skip) |-> (&tag_en) && (&data_en)); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (tag_en == '0) && (data_en == '0) && !skip); // R2
    AST_HIT_NO_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> (tag_en == '0) && req_valid); // R3
    AST_HIT_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> ($countones(data_en) == 1)); // R4
    AST_INV_BLOCKS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && req_valid && same_key) |-> !skip); // R7
    AST_AWAIT_AFTER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !skip) |=> (state == ST_AWAIT)); // R9
    AST_IDLE_AFTER_NOMISS: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !skip) |=> (state == ST_IDLE)); // R9
endmodule

bind tagskip_buf tagskip_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .WAYS(WAYS)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .inv_valid(inv_valid), .inv_addr(inv_addr), .tag_en(tag_en),
    .data_en(data_en), .skip(skip), .state(state)
);

// File: tb/tagskip_buf_tb.sv
`timescale 1ns/1ps
module tagskip_buf_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, rsp_hit, rsp_way, inv_valid;
    logic [31:0] req_addr, inv_addr;
    logic [1:0]  tag_en, data_en;
    logic        skip;

    always #2.5 clk = ~clk;

    tagskip_buf dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_hit(rsp_hit), .rsp_way(rsp_way), .inv_valid(inv_valid),
        .inv_addr(inv_addr), .tag_en(tag_en), .data_en(data_en), .skip(skip)
    );

    int n_chk = 0, n_fail = 0;

    // Reference MRU list (front = most recent) and pending-miss model.
    logic [26:0] q_key[$];
    int          q_way[$];
    bit          bp_v;
    logic [26:0] bp_key;
    bit          obs_skip;
    int          obs_way;

    // Reference cache: 4 used sets x 2 ways, holding key ids.
    bit cv[4][2];
    int cid[4][2];

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic int qfind(input logic [26:0] k);
        foreach (q_key[i]) if (q_key[i] == k) return i;
        return -1;
    endfunction

    task automatic qtouch(input logic [26:0] k, input int w);
        int p;
        p = qfind(k);
        if (p >= 0) begin q_key.delete(p); q_way.delete(p); end
        q_key.push_front(k);
        q_way.push_front(w);
        if (q_key.size() > 4) begin void'(q_key.pop_back()); void'(q_way.pop_back()); end
    endtask

    function automatic logic [31:0] mk(input int id, input int off);
        logic [17:0] tg;
        logic [8:0]  ix;
        tg = 18'((id >> 2) * 4099 + 7);
        ix = 9'((id & 3) * 100 + 3);
        return {tg, ix, 5'(off)};
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; req_valid = 0; req_addr = 0; rsp_hit = 0; rsp_way = 0;
        inv_valid = 0; inv_addr = 0;
        q_key.delete(); q_way.delete(); bp_v = 0; bp_key = 0;
        foreach (cv[s, w]) begin cv[s][w] = 0; cid[s][w] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle: drive at negedge, check outputs, update the model at posedge.
    task automatic cyc(input bit rv, input logic [31:0] ra, input bit rh, input int rw,
                       input bit iv, input logic [31:0] ia, input string lbl);
        logic [26:0] rk, ik;
        int  qi, ew;
        bit  es;
        string sl;
        @(negedge clk);
        req_valid = rv; req_addr = rv ? ra : 32'h0; rsp_hit = rh; rsp_way = rw[0];
        inv_valid = iv; inv_addr = ia;
        #1;
        rk = ra[31:5]; ik = ia[31:5];
        qi = qfind(rk);
        es = rv && (qi >= 0) && !(iv && ik == rk);
        ew = es ? q_way[qi] : 0;
        sl = (rv && iv && ik == rk && qi >= 0) ? "R7" : lbl;
        chk(skip == es, sl, 32'(skip), 32'(es));
        if (es) begin
            chk(tag_en == 2'b00, "R3", 32'(tag_en), 32'h0);
            chk(data_en == 2'(1 << ew), "R4", 32'(data_en), 32'(1 << ew));
        end else if (rv) begin
            chk(tag_en == 2'b11 && data_en == 2'b11, "R2", {tag_en, data_en}, 32'hf);
        end else begin
            chk(tag_en == 2'b00 && data_en == 2'b00, "R2", {tag_en, data_en}, 32'h0);
        end
        obs_skip = skip;
        obs_way  = data_en[1] ? 1 : 0;
        @(posedge clk);
        if (iv && qfind(ik) >= 0) begin
            qi = qfind(ik);
            q_key.delete(qi); q_way.delete(qi);
        end
        if (bp_v && rh && !(iv && ik == bp_key)) qtouch(bp_key, rw);
        if (es) qtouch(rk, ew);
        bp_v   = rv && !es;
        bp_key = rk;
    endtask

    task automatic fill(input logic [31:0] a, input int w);
        cyc(1, a, 0, 0, 0, 0, "R6");
        cyc(0, 0, 1, w, 0, 0, "R6");
    endtask

    initial begin
        #1ms;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] a0, a0_hi;
        process::self().srandom(32'd20250611);
        do_reset();
        a0    = mk(1, 0);
        a0_hi = a0 ^ 32'h8000_0000;

        // R1: reset state, then first access misses
        cyc(0, 0, 0, 0, 0, 0, "R1");
        cyc(1, a0, 0, 0, 0, 0, "R1");
        // R5: result in the cycle after the miss fills way 1; later results ignored
        cyc(0, 0, 1, 1, 0, 0, "R5");
        cyc(0, 0, 1, 0, 0, 0, "R5");
        cyc(0, 0, 1, 0, 0, 0, "R5");
        // R8: offset bits ignored, a high tag bit is not
        cyc(1, a0 | 32'h1f, 0, 0, 0, 0, "R8");
        cyc(1, a0_hi, 0, 0, 0, 0, "R8");
        cyc(0, 0, 0, 0, 0, 0, "R5");
        cyc(0, 0, 1, 1, 0, 0, "R5");
        cyc(1, a0_hi, 0, 0, 0, 0, "R5");
        cyc(0, 0, 0, 0, 0, 0, "R5");
        // R6: fill to capacity, promote a0, fill one more, LRU goes
        fill(mk(2, 4), 0);
        fill(mk(3, 8), 1);
        fill(mk(4, 9), 0);
        cyc(1, a0, 0, 0, 0, 0, "R6");
        fill(mk(5, 1), 1);
        cyc(1, mk(2, 0), 0, 0, 0, 0, "R6");
        cyc(1, a0, 0, 0, 0, 0, "R6");
        cyc(1, mk(3, 2), 0, 0, 0, 0, "R6");
        // R7: invalidate against a same-cycle request, then against a fill
        cyc(1, a0, 0, 0, 1, a0 | 32'h3, "R7");
        cyc(1, a0, 0, 0, 0, 0, "R7");
        cyc(1, mk(6, 0), 0, 0, 0, 0, "R7");
        cyc(0, 0, 1, 1, 1, mk(6, 7), "R7");
        cyc(1, mk(6, 0), 0, 0, 0, 0, "R7");
        cyc(0, 0, 0, 0, 0, 0, "R7");
        // R9: back-to-back misses, each filled from its own result
        cyc(1, mk(7, 0), 0, 0, 0, 0, "R9");
        cyc(1, mk(8, 0), 1, 0, 0, 0, "R9");
        cyc(0, 0, 1, 1, 0, 0, "R9");
        cyc(1, mk(7, 3), 0, 0, 0, 0, "R9");
        cyc(1, mk(8, 3), 0, 0, 0, 0, "R9");

        // Random phase against a reference cache of 16 line ids
        do_reset();
        begin
            bit pv = 0;
            int pid = 0;
            for (int n = 0; n < 4000; n++) begin
                bit rv, rh, iv, refill, flush;
                int rid, rw, iid, vic, st;
                rv = ($urandom % 4) != 0;
                rid = $urandom % 16;
                rh = 0; rw = $urandom % 2; iv = 0; iid = 0; refill = 0; flush = 0; vic = 0;
                st = pid & 3;
                if (pv) begin
                    if (cv[st][0] && cid[st][0] == pid)      begin rh = 1; rw = 0; end
                    else if (cv[st][1] && cid[st][1] == pid) begin rh = 1; rw = 1; end
                    else begin
                        refill = 1;
                        vic = $urandom % 2;
                        if (cv[st][vic]) begin iv = 1; iid = cid[st][vic]; end
                    end
                end else begin
                    rh = ($urandom % 2) != 0;
                end
                if (!iv && ($urandom % 8) == 0) begin iv = 1; iid = $urandom % 16; flush = 1; end
                if (iv && ($urandom % 4) == 0) rid = iid;
                cyc(rv, mk(rid, $urandom % 32), rh, rw, iv, mk(iid, $urandom % 32), "R6");
                if (obs_skip) begin
                    bit held;
                    held = cv[rid & 3][obs_way] && cid[rid & 3][obs_way] == rid;
                    chk(held, "R4", 32'(obs_way), 32'(rid));
                end
                if (flush) begin
                    for (int w = 0; w < 2; w++)
                        if (cv[iid & 3][w] && cid[iid & 3][w] == iid) cv[iid & 3][w] = 0;
                end
                if (refill) begin cv[st][vic] = 1; cid[st][vic] = pid; end
                pv  = rv && !obs_skip;
                pid = rid;
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule